// File: doc/BRIEF.md
# Serial Flash Chip-Select Timing Sequencer

This block frames every serial flash transfer with programmable select timing. A requester presents a target device index and a payload length in bits while the block is idle. The block then drives the chosen select low, waits a setup interval, and raises a serial clock enable for one cycle per payload bit. It keeps the select low for a hold interval and then releases it. Before it asserts any select it makes sure the select bus has been idle long enough. The idle floor is a minimum high time. When the new target differs from the previous one, a separate device-switch gap also applies, and the larger of the two wins. All intervals are 8-bit values in reference clock cycles, and a value of 0 behaves as 1.

The select output takes one of two forms. In direct mode there is one active-low line per device, up to sixteen. In encoded mode there is a binary index bus for an outside decoder, qualified by an active-low enable. A separate delay line sits beside the sequencer. It takes a bit-launch strobe from the internal clock or a strobe returned from the board, and it delivers a capture strobe a programmable number of cycles later. The data shifter uses that strobe to sample read data.

Top module: `flash_cs_seq`

## Requirements
- R1: While reset is held and right after it, every direct select line is high, the encoded enable is high, and busy, sclk_en, shift_last and cap_pulse are all low.
- R2: A select is low for exactly max(cfg_setup,1) cycles before the first cycle with sclk_en high.
- R3: sclk_en is high for exactly max(req_len,1) consecutive cycles per transaction. shift_last is high only in the final one of them.
- R4: After the last sclk_en cycle, the select stays low for exactly max(cfg_hold,1) cycles and is then released.
- R5: Between two transactions to the same device, the select stays high for at least max(cfg_idle,1) cycles. If the next request is presented in the first cycle busy is low, the gap is exactly max(cfg_idle,1,2).
- R6: When the device index changes from one transaction to the next, the high gap is max(cfg_idle,cfg_switch,1) under the same rule as R5, with the same floor of 2.
- R7: busy goes high the cycle after a request is accepted and falls in the cycle the select is released. A request presented while busy is ignored and starts no transaction.
- R8: Direct mode (cfg_encoded=0): during a transaction only bit req_dev of cs_n is low, and cs_enc_n stays high.
- R9: Encoded mode (cfg_encoded=1): cs_n stays all ones. cs_enc equals the device index, and cs_enc_n is low for the whole transaction, with cs_enc steady while it is low.
- R10: A pulse on the selected strobe appears on cap_pulse exactly cfg_cap_dly cycles later. A delay of 0 passes the pulse in the same cycle.
- R11: cfg_cap_ret=1 selects return_pulse and cfg_cap_ret=0 selects launch_pulse. A pulse on the unselected source gives no cap_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transaction request, taken only when busy is low |
| req_dev | input | 4 | Target device index |
| req_len | input | 16 | Payload length in bits (0 acts as 1) |
| cfg_setup | input | 8 | Select-low to first bit delay, cycles |
| cfg_hold | input | 8 | Last bit to select release delay, cycles |
| cfg_idle | input | 8 | Minimum select-high time, cycles |
| cfg_switch | input | 8 | Device change gap, cycles |
| cfg_encoded | input | 1 | 1 selects encoded select bus, 0 direct lines |
| cfg_cap_ret | input | 1 | Capture strobe source: 1 returned, 0 launch |
| cfg_cap_dly | input | 3 | Capture delay in cycles |
| launch_pulse | input | 1 | Internal bit-launch strobe |
| return_pulse | input | 1 | Strobe from the returned clock |
| busy | output | 1 | Transaction in progress |
| cs_n | output | 16 | Direct active-low selects |
| cs_enc | output | 4 | Encoded device index |
| cs_enc_n | output | 1 | Active-low enable for the encoded index |
| sclk_en | output | 1 | Serial clock enable, one cycle per bit |
| shift_last | output | 1 | Marks the last bit cycle |
| cap_pulse | output | 1 | Delayed capture strobe |

## Verification
A table of back-to-back transactions varies device, length, all four delays and the select mode. Each transaction's setup, bit and hold lengths are measured, which separates the zero-means-one floor from a literal zero. Consecutive entries alternate between the same and a different device, with idle and switch values set so that each one wins in turn. This shows whether the gap follows the larger delay or only one of them. Directed cases cover reset, a request issued mid-transfer that must be dropped, and capture pulses on each source at several delays, so that a wrong tap or a crossed source shows up.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int unsigned FCS_DLY_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_SETUP,
        PH_SHIFT,
        PH_HOLD
    } fcs_phase_e;

    typedef struct packed {
        logic [FCS_DLY_W-1:0] setup;
        logic [FCS_DLY_W-1:0] hold;
        logic [FCS_DLY_W-1:0] idle;
        logic [FCS_DLY_W-1:0] swtch;
    } fcs_timing_t;

    function automatic logic [FCS_DLY_W-1:0] fcs_floor1(input logic [FCS_DLY_W-1:0] v);
        return (v == '0) ? FCS_DLY_W'(1) : v;
    endfunction

    function automatic logic [FCS_DLY_W-1:0] fcs_max(input logic [FCS_DLY_W-1:0] a,
                                                     input logic [FCS_DLY_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fcs_gap_track.sv
module fcs_gap_track
    import fcs_pkg::*;
#(
    parameter int unsigned SEL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rel,
    input  logic [SEL_W-1:0]     rel_dev,
    output logic [FCS_DLY_W-1:0] gap_cnt,
    output logic [SEL_W-1:0]     last_dev,
    output logic                 have_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt   <= '1;
            last_dev  <= '0;
            have_last <= 1'b0;
        end else if (rel) begin
            gap_cnt   <= FCS_DLY_W'(1);
            last_dev  <= rel_dev;
            have_last <= 1'b1;
        end else if (gap_cnt != '1) begin
            gap_cnt <= gap_cnt + FCS_DLY_W'(1);
        end
    end
endmodule

// File: rtl/fcs_phase_fsm.sv
module fcs_phase_fsm
    import fcs_pkg::*;
#(
    parameter int unsigned SEL_W = 4,
    parameter int unsigned LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [SEL_W-1:0]     req_dev,
    input  logic [LEN_W-1:0]     req_len,
    input  fcs_timing_t          req_tim,
    input  logic                 req_enc,
    input  logic [FCS_DLY_W-1:0] gap_cnt,
    input  logic [SEL_W-1:0]     last_dev,
    input  logic                 have_last,
    output logic [SEL_W-1:0]     cur_dev,
    output logic                 cur_enc,
    output logic                 cs_active,
    output logic                 busy,
    output logic                 sclk_en,
    output logic                 shift_last,
    output logic                 rel
);
    localparam int unsigned CNT_W = (LEN_W > FCS_DLY_W) ? LEN_W : FCS_DLY_W;

    fcs_phase_e        phase;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  len_q;
    fcs_timing_t       tim_q;
    logic [FCS_DLY_W-1:0] need;
    logic              gap_ok;
    logic              cnt_zero;

    always_comb begin
        need = fcs_floor1(tim_q.idle);
        if (have_last && (cur_dev != last_dev))
            need = fcs_max(need, fcs_floor1(tim_q.swtch));
        gap_ok = (gap_cnt >= need);
    end

    assign cnt_zero   = (cnt == '0);
    assign busy       = (phase != PH_IDLE);
    assign cs_active  = (phase == PH_SETUP) || (phase == PH_SHIFT) || (phase == PH_HOLD);
    assign sclk_en    = (phase == PH_SHIFT);
    assign shift_last = (phase == PH_SHIFT) && cnt_zero;
    assign rel        = (phase == PH_HOLD) && cnt_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            len_q   <= '0;
            tim_q   <= '0;
            cur_dev <= '0;
            cur_enc <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (req_valid) begin
                    cur_dev <= req_dev;
                    cur_enc <= req_enc;
                    tim_q   <= req_tim;
                    len_q   <= (req_len == '0) ? LEN_W'(1) : req_len;
                    phase   <= PH_GAP;
                end
                PH_GAP: if (gap_ok) begin
                    cnt   <= CNT_W'(fcs_floor1(tim_q.setup)) - CNT_W'(1);
                    phase <= PH_SETUP;
                end
                PH_SETUP: if (cnt_zero) begin
                    cnt   <= CNT_W'(len_q) - CNT_W'(1);
                    phase <= PH_SHIFT;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                PH_SHIFT: if (cnt_zero) begin
                    cnt   <= CNT_W'(fcs_floor1(tim_q.hold)) - CNT_W'(1);
                    phase <= PH_HOLD;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                PH_HOLD: if (cnt_zero) begin
                    phase <= PH_IDLE;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fcs_cs_drive.sv
module fcs_cs_drive #(
    parameter int unsigned NUM_CS = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic              active,
    input  logic              enc,
    input  logic [SEL_W-1:0]  dev,
    output logic [NUM_CS-1:0] cs_n,
    output logic [SEL_W-1:0]  cs_enc,
    output logic              cs_enc_n
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        assign cs_n[g] = !(active && !enc && (dev == SEL_W'(g)));
    end

    assign cs_enc   = dev;
    assign cs_enc_n = !(active && enc);
endmodule

// File: rtl/fcs_cap_delay.sv
module fcs_cap_delay #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned DLY_SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch_pulse,
    input  logic                 return_pulse,
    input  logic                 use_ret,
    input  logic [DLY_SEL_W-1:0] dly,
    output logic                 cap_pulse
);
    logic [DEPTH-1:0] tap;

    assign tap[0] = use_ret ? return_pulse : launch_pulse;

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) tap[g] <= 1'b0;
            else     tap[g] <= tap[g-1];
        end
    end

    assign cap_pulse = tap[dly];
endmodule

// File: rtl/flash_cs_seq.sv
module flash_cs_seq
    import fcs_pkg::*;
#(
    parameter int unsigned NUM_CS    = 16,
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned CAP_DEPTH = 8,
    localparam int unsigned SEL_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned CAP_W    = (CAP_DEPTH > 1) ? $clog2(CAP_DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [SEL_W-1:0]     req_dev,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [FCS_DLY_W-1:0] cfg_setup,
    input  logic [FCS_DLY_W-1:0] cfg_hold,
    input  logic [FCS_DLY_W-1:0] cfg_idle,
    input  logic [FCS_DLY_W-1:0] cfg_switch,
    input  logic                 cfg_encoded,
    input  logic                 cfg_cap_ret,
    input  logic [CAP_W-1:0]     cfg_cap_dly,
    input  logic                 launch_pulse,
    input  logic                 return_pulse,
    output logic                 busy,
    output logic [NUM_CS-1:0]    cs_n,
    output logic [SEL_W-1:0]     cs_enc,
    output logic                 cs_enc_n,
    output logic                 sclk_en,
    output logic                 shift_last,
    output logic                 cap_pulse
);
    fcs_timing_t          tim;
    logic [FCS_DLY_W-1:0] gap_cnt;
    logic [SEL_W-1:0]     last_dev;
    logic                 have_last;
    logic [SEL_W-1:0]     cur_dev;
    logic                 cur_enc;
    logic                 cs_active;
    logic                 rel;

    assign tim = '{setup: cfg_setup, hold: cfg_hold, idle: cfg_idle, swtch: cfg_switch};

    fcs_gap_track #(.SEL_W(SEL_W)) u_gap (
        .clk(clk), .rst(rst), .rel(rel), .rel_dev(cur_dev),
        .gap_cnt(gap_cnt), .last_dev(last_dev), .have_last(have_last)
    );

    fcs_phase_fsm #(.SEL_W(SEL_W), .LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dev(req_dev),
        .req_len(req_len), .req_tim(tim), .req_enc(cfg_encoded),
        .gap_cnt(gap_cnt), .last_dev(last_dev), .have_last(have_last),
        .cur_dev(cur_dev), .cur_enc(cur_enc), .cs_active(cs_active),
        .busy(busy), .sclk_en(sclk_en), .shift_last(shift_last), .rel(rel)
    );

    fcs_cs_drive #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_drv (
        .active(cs_active), .enc(cur_enc), .dev(cur_dev),
        .cs_n(cs_n), .cs_enc(cs_enc), .cs_enc_n(cs_enc_n)
    );

    fcs_cap_delay #(.DEPTH(CAP_DEPTH)) u_cap (
        .clk(clk), .rst(rst), .launch_pulse(launch_pulse),
        .return_pulse(return_pulse), .use_ret(cfg_cap_ret),
        .dly(cfg_cap_dly), .cap_pulse(cap_pulse)
    );
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
    parameter int unsigned NUM_CS = 16,
    parameter int unsigned SEL_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic [NUM_CS-1:0] cs_n,
    input logic [SEL_W-1:0]  cs_enc,
    input logic              cs_enc_n,
    input logic              sclk_en,
    input logic              shift_last
);
    logic cs_any;
    assign cs_any = !(&cs_n) || !cs_enc_n;

    // R8
    one_select_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));

    // R9
    mode_exclusive_chk: assert property (@(posedge clk) disable iff (rst) !cs_enc_n |-> (&cs_n));

    // R9
    enc_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_enc_n && !$past(cs_enc_n)) |-> $stable(cs_enc));

    // R3
    last_in_shift_chk: assert property (@(posedge clk) disable iff (rst) shift_last |-> sclk_en);

    // R2
    setup_before_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_en) |-> $past(cs_any));

    // R4
    hold_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_en) |-> cs_any);

    // R7
    busy_cover_chk: assert property (@(posedge clk) disable iff (rst) cs_any |-> busy);

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !cs_any);
endmodule

bind flash_cs_seq fcs_chk #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_fcs_chk (
    .clk(clk), .rst(rst), .busy(busy), .cs_n(cs_n), .cs_enc(cs_enc),
    .cs_enc_n(cs_enc_n), .sclk_en(sclk_en), .shift_last(shift_last)
);

// File: tb/flash_cs_seq_bench.sv
`timescale 1ns/1ps
module flash_cs_seq_bench;
    localparam int NCS = 16;
    localparam int CAPD = 8;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_dev = '0;
    logic [15:0] req_len = '0;
    logic [7:0]  cfg_setup = '0, cfg_hold = '0, cfg_idle = '0, cfg_switch = '0;
    logic        cfg_encoded = 1'b0, cfg_cap_ret = 1'b0;
    logic [2:0]  cfg_cap_dly = '0;
    logic        launch_pulse = 1'b0, return_pulse = 1'b0;
    logic        busy;
    logic [15:0] cs_n;
    logic [3:0]  cs_enc;
    logic        cs_enc_n, sclk_en, shift_last, cap_pulse;

    always #4 clk = ~clk;

    flash_cs_seq u_flash_cs_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dev(req_dev),
        .req_len(req_len), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
        .cfg_idle(cfg_idle), .cfg_switch(cfg_switch), .cfg_encoded(cfg_encoded),
        .cfg_cap_ret(cfg_cap_ret), .cfg_cap_dly(cfg_cap_dly),
        .launch_pulse(launch_pulse), .return_pulse(return_pulse),
        .busy(busy), .cs_n(cs_n), .cs_enc(cs_enc), .cs_enc_n(cs_enc_n),
        .sclk_en(sclk_en), .shift_last(shift_last), .cap_pulse(cap_pulse)
    );

    typedef struct packed {
        logic [3:0]  dev;
        logic [15:0] len;
        logic [7:0]  su;
        logic [7:0]  ho;
        logic [7:0]  id;
        logic [7:0]  sw;
        logic        enc;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'd8, 8'd3, 8'd2, 8'd4,  8'd6,  1'b0},
        '{4'd0,  16'd4, 8'd0, 8'd0, 8'd5,  8'd9,  1'b0},
        '{4'd3,  16'd1, 8'd1, 8'd1, 8'd2,  8'd7,  1'b0},
        '{4'd3,  16'd0, 8'd2, 8'd3, 8'd0,  8'd0,  1'b1},
        '{4'd15, 16'd6, 8'd4, 8'd1, 8'd10, 8'd3,  1'b1},
        '{4'd9,  16'd3, 8'd1, 8'd5, 8'd1,  8'd12, 1'b0},
        '{4'd9,  16'd2, 8'd7, 8'd0, 8'd3,  8'd1,  1'b0}
    };

    int checks = 0;
    int errors = 0;

    // monitor results
    int m_setup, m_shift, m_hold, m_gap, m_last_cnt, m_last_pos, tx_count, gap_run, mph;
    bit m_mode_ok;
    logic [15:0] m_csn;
    logic [3:0]  m_enc;
    logic        m_encn;
    logic        prev_any;
    logic        cs_any;
    assign cs_any = !(&cs_n) || !cs_enc_n;

    always @(negedge clk) begin
        if (rst) begin
            tx_count = 0; gap_run = 0; prev_any = 1'b0; mph = 0;
            m_setup = 0; m_shift = 0; m_hold = 0; m_gap = 0;
            m_last_cnt = 0; m_last_pos = -1; m_mode_ok = 1'b1;
            m_csn = '1; m_enc = '0; m_encn = 1'b1;
        end else begin
            if (!cs_any) begin
                if (prev_any) tx_count++;
                gap_run++;
                mph = 0;
            end else begin
                if (!prev_any) begin
                    m_gap = gap_run; gap_run = 0;
                    m_setup = 0; m_shift = 0; m_hold = 0;
                    m_last_cnt = 0; m_last_pos = -1;
                    m_csn = cs_n; m_enc = cs_enc; m_encn = cs_enc_n;
                    m_mode_ok = 1'b1; mph = 1;
                end
                if (cs_n != m_csn || cs_enc_n != m_encn || (!cs_enc_n && cs_enc != m_enc))
                    m_mode_ok = 1'b0;
                if (sclk_en) begin
                    if (shift_last) begin m_last_cnt++; m_last_pos = m_shift; end
                    m_shift++;
                end else if (m_shift == 0) m_setup++;
                else m_hold++;
            end
            prev_any = cs_any;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            finish_run();
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int fl1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic apply(input vec_t v);
        req_dev = v.dev; req_len = v.len;
        cfg_setup = v.su; cfg_hold = v.ho; cfg_idle = v.id; cfg_switch = v.sw;
        cfg_encoded = v.enc;
    endtask

    // issues the request, then waits until the transaction is released
    task automatic run_tx(input vec_t v);
        apply(v);
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        chk(busy == 1'b1, "R7 busy after accept", busy, 1);
        while (busy) tick();
    endtask

    task automatic check_tx(input vec_t v);
        logic [15:0] exp_csn;
        int nb;
        nb = fl1(int'(v.len));
        chk(m_setup == fl1(int'(v.su)), "R2 setup cycles", m_setup, fl1(int'(v.su)));
        chk(m_shift == nb, "R3 bit cycles", m_shift, nb);
        chk(m_last_cnt == 1 && m_last_pos == nb - 1, "R3 last bit position", m_last_pos, nb - 1);
        chk(m_hold == fl1(int'(v.ho)), "R4 hold cycles", m_hold, fl1(int'(v.ho)));
        if (v.enc) begin
            chk(m_mode_ok && m_csn == 16'hFFFF && m_encn == 1'b0 && m_enc == v.dev,
                "R9 encoded select", int'(m_enc), int'(v.dev));
        end else begin
            exp_csn = ~(16'h1 << v.dev);
            chk(m_mode_ok && m_csn == exp_csn && m_encn == 1'b1,
                "R8 direct select", int'(m_csn), int'(exp_csn));
        end
    endtask

    task automatic cap_try(input bit use_ret, input int d, input bit on_ret, input string tag);
        int hits, pos;
        bit hit_expected;
        hits = 0; pos = -1;
        hit_expected = (use_ret == on_ret);
        cfg_cap_ret = use_ret; cfg_cap_dly = 3'(d);
        launch_pulse = 1'b0; return_pulse = 1'b0;
        for (int k = 0; k < CAPD + 2; k++) tick();
        if (on_ret) return_pulse = 1'b1; else launch_pulse = 1'b1;
        #1;
        if (cap_pulse) begin hits++; pos = 0; end
        for (int k = 1; k <= CAPD; k++) begin
            tick();
            launch_pulse = 1'b0; return_pulse = 1'b0;
            #1;
            if (cap_pulse) begin hits++; pos = k; end
        end
        if (hit_expected)
            chk(hits == 1 && pos == d, tag, pos, d);
        else
            chk(hits == 0, tag, hits, 0);
    endtask

    initial begin
        int need, exp_gap, base;
        logic [15:0] exp_csn;
        vec_t v;
        rst = 1'b1;
        repeat (3) tick();
        // R1 state during reset
        chk(cs_n == 16'hFFFF && cs_enc_n && !busy && !sclk_en && !shift_last && !cap_pulse,
            "R1 reset outputs", int'(cs_n), 16'hFFFF);
        rst = 1'b0;
        tick();
        chk(cs_n == 16'hFFFF && cs_enc_n && !busy && !sclk_en,
            "R1 after reset", int'({busy, sclk_en, cs_enc_n}), 1);

        for (int i = 0; i < NV; i++) begin
            run_tx(VECS[i]);
            check_tx(VECS[i]);
            if (i > 0) begin
                need = fl1(int'(VECS[i].id));
                if (VECS[i].dev != VECS[i-1].dev) need = mx(need, fl1(int'(VECS[i].sw)));
                exp_gap = mx(need, 2);
                if (VECS[i].dev != VECS[i-1].dev)
                    chk(m_gap == exp_gap, "R6 switch gap", m_gap, exp_gap);
                else
                    chk(m_gap == exp_gap, "R5 idle gap", m_gap, exp_gap);
            end
        end

        // R7 request during a transfer is dropped
        v = '{4'd2, 16'd20, 8'd2, 8'd2, 8'd1, 8'd1, 1'b0};
        base = tx_count;
        apply(v);
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        repeat (6) tick();
        req_dev = 4'd7; req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        while (busy) tick();
        repeat (12) tick();
        chk(tx_count == base + 1, "R7 ignored request count", tx_count, base + 1);
        exp_csn = ~(16'h1 << 2);
        chk(m_csn == exp_csn && cs_n == 16'hFFFF && !busy, "R7 ignored request target",
            int'(m_csn), int'(exp_csn));

        // R10 capture delays on launch source
        cap_try(1'b0, 0, 1'b0, "R10 delay 0");
        cap_try(1'b0, 2, 1'b0, "R10 delay 2");
        cap_try(1'b0, 7, 1'b0, "R10 delay 7");
        // R11 source selection
        cap_try(1'b1, 3, 1'b0, "R11 launch ignored when return chosen");
        cap_try(1'b1, 3, 1'b1, "R11 return source delay 3");
        cap_try(1'b0, 4, 1'b1, "R11 return ignored when launch chosen");

        finish_run();
    end
endmodule